// File: doc/BRIEF.md
# SPI Slave Indirect Register Port

This block is a serial slave front end that gives an external host access to an internal 256-entry, 8-bit register file. It uses four serial signals: an active-low select, a serial clock, a receive line and a transmit line. Access is indirect. The host first runs an address cycle that loads an internal pointer. Data cycles then read or write the register that the pointer selects. The pointer does not step on its own.

Every transaction is 16 serial clocks long: a control byte, then a data byte, both sent most significant bit first. The control byte uses only two bits, a read/write flag and an address/data flag. The six bits above them must be zero. Select may be released between the two bytes and the transfer then resumes with the data byte. The block leaves reset in parallel-bus mode and moves to serial mode on the first serial clock rising edge it sees. The serial inputs are asynchronous to the system clock. They are synchronized and edge-detected, so each serial clock half period must last at least six system clocks. The register file port takes one access per transaction and applies no back-pressure: there is no stall path, and a read or write always completes in a fixed number of cycles.

Top module: `spi_regport`

## Requirements
- R1: While and after reset (active-high `rst`, with `spi_sel_n` held high), `spi_mode`, `spi_miso` and `cmd_err` are 0, the pointer is 0 and every register holds 0.
- R2: The first synchronized rising edge of `spi_sck` sets `spi_mode` to 1. It stays 1 until the next reset. If select is low, that same edge is taken as the first bit of a transfer.
- R3: `spi_mosi` is sampled on `spi_sck` rising edges only while `spi_sel_n` is low. Rising edges while select is high are not counted. Bytes travel MSB first, and control-byte bit 1 is read/write (1 = read) and bit 0 is address/data (1 = address).
- R4: An address write loads the data byte into the 8-bit pointer. An address read shifts out the current pointer.
- R5: A data write stores the data byte in the register at the pointer. A data read shifts out that register MSB first. Bit 7 is valid before the first rising edge of the data byte, and each later bit follows a falling edge.
- R6: `spi_miso` is 0 during every control byte and during the data byte of a write.
- R7: A control byte with any of bits 7..2 set raises `cmd_err` until its data byte completes. That data byte leaves the pointer and all registers unchanged, and `spi_miso` stays 0 for it.
- R8: Releasing select between the control byte and the data byte keeps the control byte. The data byte sent after select returns low completes the transaction.
- R9: Releasing select in the middle of a byte discards the bits of that byte already received. The byte restarts from its MSB, a received control byte is kept, and a read data byte is shifted out again from bit 7.
- R10: Data reads and data writes never change the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sel_n | input | 1 | Serial select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock from the host, asynchronous |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_mode | output | 1 | 1 once the serial interface has taken over from the parallel bus |
| cmd_err | output | 1 | Current control byte has a reserved bit set |

## Verification
The in-RTL assertions check, on every cycle:
- the serial-mode flag never drops;
- the pointer and the error flag change only on the cycle after a serial clock rising edge;
- a deselect clears the bit counter;
- a deselect in the data phase keeps the pending control byte;
- a register read and a register write never share a cycle.

The bit ordering, the read data values, the timing of bit 7 and the model of pointer and register contents can only be shown by the bench scenarios. These include pauses between bytes, bytes cut off mid-way and rejected control bytes, with every returned bit compared against the bench model.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  // transaction phase: which byte of the 16-bit frame is being shifted
  typedef enum logic {
    PH_CTRL = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // decoded control byte held across the data byte
  typedef struct packed {
    logic rw;   // 1 = read
    logic ad;   // 1 = data byte is an address
    logic bad;  // reserved bit was set
  } ctl_t;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic sel_n_i,
  input  logic mosi_i,
  output logic rise_o,
  output logic fall_o,
  output logic sel_hi_o,
  output logic mosi_o
);

  localparam int LAST = STAGES;

  logic [LAST:0] sck_p, sel_p, mosi_p;
  logic          rise_q, fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p  <= '0;
      sel_p  <= '1;
      mosi_p <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sck_p  <= {sck_p[LAST-1:0], sck_i};
      sel_p  <= {sel_p[LAST-1:0], sel_n_i};
      mosi_p <= {mosi_p[LAST-1:0], mosi_i};
      rise_q <= sck_p[LAST-1] & ~sck_p[LAST];
      fall_q <= ~sck_p[LAST-1] & sck_p[LAST];
    end
  end

  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign sel_hi_o = sel_p[LAST];
  assign mosi_o   = mosi_p[LAST];

endmodule

// File: rtl/spi_regport_rf.sv
module spi_regport_rf #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      if (re_i) rdata_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/spi_regport_seq.sv
module spi_regport_seq
  import spi_regport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sel_hi_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic [ADDR_W-1:0] rf_addr_o,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              rf_re_o,
  output logic              miso_o,
  output logic              mode_o,
  output logic              err_o
);

  localparam int                CNT_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0]  LAST   = CNT_W'(DATA_W - 1);
  localparam int                RW_BIT = 1;
  localparam int                AD_BIT = 0;

  logic [DATA_W-1:0] shreg_q, rd_hold_q, wdata_q, byte_w;
  logic [CNT_W-1:0]  bitcnt_q, tx_idx_q;
  logic [ADDR_W-1:0] ptr_q;
  phase_e            phase_q;
  ctl_t              ctl_q;
  logic              we_q, re_q, pend1_q, pend2_q, mode_q;
  logic              done_w, bad_w, rd_act_w;

  assign byte_w   = {shreg_q[DATA_W-2:0], mosi_i};
  assign done_w   = rise_i && !sel_hi_i && (bitcnt_q == LAST);
  assign bad_w    = byte_w[DATA_W-1:RW_BIT+1] != '0;
  assign rd_act_w = (phase_q == PH_DATA) && ctl_q.rw && !ctl_q.bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q   <= '0;
      rd_hold_q <= '0;
      wdata_q   <= '0;
      bitcnt_q  <= '0;
      tx_idx_q  <= '0;
      ptr_q     <= '0;
      phase_q   <= PH_CTRL;
      ctl_q     <= '0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      pend1_q   <= 1'b0;
      pend2_q   <= 1'b0;
      mode_q    <= 1'b0;
    end else begin
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      pend1_q <= 1'b0;
      pend2_q <= pend1_q;
      if (rise_i) mode_q <= 1'b1;
      if (pend2_q) rd_hold_q <= rf_rdata_i;
      if (sel_hi_i) begin
        bitcnt_q <= '0;
        tx_idx_q <= '0;
      end else if (rise_i) begin
        shreg_q  <= byte_w;
        bitcnt_q <= done_w ? '0 : bitcnt_q + 1'b1;
        if (done_w) begin
          if (phase_q == PH_CTRL) begin
            ctl_q    <= '{rw: byte_w[RW_BIT], ad: byte_w[AD_BIT], bad: bad_w};
            phase_q  <= PH_DATA;
            tx_idx_q <= '0;
            if (!bad_w && byte_w[RW_BIT]) begin
              if (byte_w[AD_BIT]) rd_hold_q <= DATA_W'(ptr_q);
              else begin
                re_q    <= 1'b1;
                pend1_q <= 1'b1;
              end
            end
          end else begin
            phase_q   <= PH_CTRL;
            ctl_q.bad <= 1'b0;
            if (!ctl_q.bad && !ctl_q.rw) begin
              if (ctl_q.ad) ptr_q <= ADDR_W'(byte_w);
              else begin
                we_q    <= 1'b1;
                wdata_q <= byte_w;
              end
            end
          end
        end
      end else if (fall_i && phase_q == PH_DATA) begin
        tx_idx_q <= bitcnt_q;
      end
    end
  end

  assign rf_addr_o  = ptr_q;
  assign rf_we_o    = we_q;
  assign rf_wdata_o = wdata_q;
  assign rf_re_o    = re_q;
  assign miso_o     = rd_act_w ? rd_hold_q[LAST - tx_idx_q] : 1'b0;
  assign mode_o     = mode_q;
  assign err_o      = (phase_q == PH_DATA) && ctl_q.bad;

  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> mode_q);

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr_q) |-> $past(rise_i));

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> $past(rise_i));

  // R9
  desel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sel_hi_i |=> (bitcnt_q == '0));

  // R8
  data_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_hi_i && phase_q == PH_DATA) |=> (phase_q == PH_DATA));

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sel_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_mode,
  output logic cmd_err
);

  logic              rise_w, fall_w, sel_hi_w, mosi_w;
  logic [ADDR_W-1:0] rf_addr_w;
  logic              rf_we_w, rf_re_w;
  logic [DATA_W-1:0] rf_wdata_w, rf_rdata_w;

  spi_regport_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .sck_i    (spi_sck),
    .sel_n_i  (spi_sel_n),
    .mosi_i   (spi_mosi),
    .rise_o   (rise_w),
    .fall_o   (fall_w),
    .sel_hi_o (sel_hi_w),
    .mosi_o   (mosi_w)
  );

  spi_regport_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) seq_i (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .sel_hi_i   (sel_hi_w),
    .mosi_i     (mosi_w),
    .rf_rdata_i (rf_rdata_w),
    .rf_addr_o  (rf_addr_w),
    .rf_we_o    (rf_we_w),
    .rf_wdata_o (rf_wdata_w),
    .rf_re_o    (rf_re_w),
    .miso_o     (spi_miso),
    .mode_o     (spi_mode),
    .err_o      (cmd_err)
  );

  spi_regport_rf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) rf_i (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (rf_addr_w),
    .we_i    (rf_we_w),
    .wdata_i (rf_wdata_w),
    .re_i    (rf_re_w),
    .rdata_o (rf_rdata_w)
  );

  // R5
  rf_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rf_we_w && rf_re_w));

endmodule

// File: tb/spi_regport_tb_top.sv
`timescale 1ns/1ps
module spi_regport_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso, mode, err;

  localparam int HALF = 6;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;

  always #2.5 clk = ~clk;

  spi_regport dut_i (
    .clk       (clk),
    .rst       (rst),
    .spi_sel_n (sel_n),
    .spi_sck   (sck),
    .spi_mosi  (mosi),
    .spi_miso  (miso),
    .spi_mode  (mode),
    .cmd_err   (err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: drive while low, sample miso just before the rise
  task automatic bit_x(input logic b, input logic exp_b, input string req);
    mosi = b;
    wait_clk(HALF);
    chk(req, int'(miso), int'(exp_b));
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic frame(input logic [7:0] c, input logic [7:0] d,
                       input bit pause, input int cut_bits);
    logic       bad, rd, ad;
    logic [7:0] expv;
    bad  = |c[7:2];
    rd   = c[1];
    ad   = c[0];
    expv = (rd && !bad) ? (ad ? ref_ptr : ref_mem[ref_ptr]) : 8'h00;
    sel_n = 1'b0;
    wait_clk(HALF);
    for (int i = 7; i >= 0; i--) bit_x(c[i], 1'b0, "R6 miso low in control byte");
    wait_clk(2);
    chk("R7 cmd_err after control byte", int'(err), int'(bad));
    if (pause) begin
      sel_n = 1'b1;
      wait_clk(4 * HALF);
      chk("R8 control kept over deselect", int'(err), int'(bad));
      sel_n = 1'b0;
      wait_clk(HALF);
    end
    if (cut_bits > 0) begin
      for (int i = 7; i > 7 - cut_bits; i--)
        bit_x(d[i], expv[i], "R9 partial data byte");
      sel_n = 1'b1;
      wait_clk(4 * HALF);
      sel_n = 1'b0;
      wait_clk(HALF);
    end
    for (int i = 7; i >= 0; i--) begin
      if (bad)            bit_x(d[i], 1'b0, "R7 miso low for rejected byte");
      else if (!rd)       bit_x(d[i], 1'b0, "R6 miso low in write data");
      else if (ad)        bit_x(d[i], expv[i], "R4 pointer read bit");
      else                bit_x(d[i], expv[i], "R5 data read bit");
    end
    if (!bad && !rd) begin
      if (ad) ref_ptr = d;
      else    ref_mem[ref_ptr] = d;
    end
    wait_clk(HALF);
    sel_n = 1'b1;
    wait_clk(2 * HALF);
    chk("R7 cmd_err clear after data byte", int'(err), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    ref_ptr = 8'h00;
    wait_clk(5);
    chk("R1 mode in reset", int'(mode), 0);
    chk("R1 miso in reset", int'(miso), 0);
    chk("R1 cmd_err in reset", int'(err), 0);
    rst = 1'b0;
    wait_clk(5);
    chk("R1 mode after reset", int'(mode), 0);
    chk("R1 miso after reset", int'(miso), 0);
    sel_n = 1'b0;
    wait_clk(3 * HALF);
    chk("R2 select alone keeps parallel mode", int'(mode), 0);
    sel_n = 1'b1;
    wait_clk(3 * HALF);

    // R2: first rise is the first bit; R1 register reads zero
    frame(8'h02, 8'h00, 0, 0);
    chk("R2 serial mode set", int'(mode), 1);
    frame(8'h01, 8'h05, 0, 0);           // R4 address write
    frame(8'h03, 8'h00, 0, 0);           // R4 address read
    frame(8'h00, 8'hA5, 0, 0);           // R5 data write
    frame(8'h02, 8'h00, 0, 0);           // R5 data read
    frame(8'h02, 8'h00, 0, 0);           // R10 no stepping
    frame(8'h03, 8'h00, 0, 0);           // R10 pointer unchanged
    frame(8'h01, 8'h80, 0, 0);
    frame(8'h00, 8'h3C, 0, 0);
    frame(8'h01, 8'h05, 0, 0);
    frame(8'h02, 8'h00, 0, 0);           // R5 A5 still at 5

    // R7 rejected control bytes
    frame(8'h41, 8'h77, 0, 0);
    frame(8'h84, 8'h11, 0, 0);
    frame(8'h86, 8'h00, 0, 0);
    frame(8'h03, 8'h00, 0, 0);
    frame(8'h02, 8'h00, 0, 0);

    // R8 pause between bytes
    frame(8'h00, 8'h5A, 1, 0);
    frame(8'h02, 8'h00, 1, 0);
    frame(8'h03, 8'h00, 1, 0);

    // R9 cut mid-byte
    frame(8'h00, 8'hC3, 0, 3);
    frame(8'h02, 8'h00, 0, 5);
    frame(8'h01, 8'h80, 1, 2);
    frame(8'h03, 8'h00, 0, 0);
    frame(8'h02, 8'h00, 0, 0);

    // R9 abort inside a control byte, then a fresh frame
    sel_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 3; i++) bit_x(1'b1, 1'b0, "R9 partial control byte");
    sel_n = 1'b1;
    wait_clk(4 * HALF);
    frame(8'h02, 8'h00, 0, 0);

    // R3 clock edges while deselected are not counted
    for (int i = 0; i < 3; i++) begin
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    frame(8'h01, 8'h05, 0, 0);
    frame(8'h02, 8'h00, 0, 0);
    chk("R3 deselected edges ignored, pointer", int'(ref_ptr), 8'h05);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule